// File: doc/BRIEF.md
# Power-Up Reset Hold Sequencer

This block keeps the rest of the chip in reset after a supply event until the supply and the clock can be trusted. A power-on or brown-out event, or the synchronous reset of the block itself, starts a chain of timed stages:

- a power-on delay;
- an optional power-up timer;
- a clock start-up wait that depends on the oscillator mode;
- for the high-speed crystal mode with frequency multiplication, a further lock interval.

The internal reset hold is released only when the last stage that applies has expired. Every stage has its own busy flag on the outputs.

Durations are parameter counts. The power-on delay, power-up timer and lock interval count pulses of a slow timebase tick. The crystal start-up wait and the external-clock wait count cycles of the oscillator clock.

A wake-up from sleep reruns only the clock stages. A master clear taken while the chip is running asserts the hold for a single cycle. The oscillator mode and the power-up timer enable are sampled when a power event occurs, and they stay in force until the next power event.

Top module: `pwrup_hold_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `hold_rst` is 1, `pod_busy` is 1 and every other busy flag is 0. `rst` acts as a power event that samples `osc_mode` and `pwrt_en`, and the full sequence then runs to release.
- R2: A `por_evt` or `bor_evt` pulse in any stage sends the block back to the power-on delay on the next edge, and the whole sequence runs again. A power event takes precedence over `mclr_evt` and `wake_evt` arriving in the same cycle.
- R3: The power-on delay (`pod_busy`) lasts exactly POD_TICKS tick pulses.
- R4: The power-up timer (`pwrt_busy`) lasts exactly PWRT_TICKS tick pulses. It runs only after a power event, and only when `pwrt_en` was 1 at that event.
- R5: The crystal start-up wait (`ost_busy`) lasts exactly OST_CYCLES clock cycles. It runs only for `osc_mode` codes 0 (low power), 1 (crystal), 2 (high speed) and 3 (high speed with multiplier).
- R6: For `osc_mode` codes 6 and 7 (external clock, with or without the spare pin), an external-clock wait (`extclk_busy`) of EXT_CYCLES clock cycles runs in place of the crystal wait. Codes 4 and 5 (RC) have no clock stage.
- R7: Only for `osc_mode` code 3, a lock interval (`lock_busy`) of LOCK_TICKS tick pulses follows the crystal wait.
- R8: The stages run in this order: power-on delay, power-up timer, clock stage, lock interval. `hold_rst` falls on the edge where the last applicable stage expires. At most one busy flag is high at any time.
- R9: A `wake_evt` pulse while running reruns only the clock stage and the lock interval of the sampled mode. In RC modes it has no effect.
- R10: A `mclr_evt` pulse while running holds `hold_rst` for exactly one cycle with no busy flag set. If it arrives in the same cycle as a wake, it takes precedence over the wake.
- R11: `mclr_evt` and `wake_evt` have no effect while a sequence is in progress. The stage order and the durations stay unchanged.
- R12: A change of `osc_mode` or `pwrt_en` after a power event has no effect until the next power event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power event |
| por_evt | input | 1 | Power-on event pulse |
| bor_evt | input | 1 | Brown-out event pulse |
| mclr_evt | input | 1 | Master clear pulse |
| wake_evt | input | 1 | Wake-from-sleep pulse |
| osc_mode | input | 3 | Oscillator mode code |
| pwrt_en | input | 1 | Power-up timer enable |
| slow_tick | input | 1 | Slow timebase pulse, one clock wide |
| hold_rst | output | 1 | Internal reset hold |
| pod_busy | output | 1 | Power-on delay running |
| pwrt_busy | output | 1 | Power-up timer running |
| ost_busy | output | 1 | Crystal start-up wait running |
| extclk_busy | output | 1 | External-clock wait running |
| lock_busy | output | 1 | Lock interval running |

## Verification
Two functions can fall in the same cycle: a restart from a power event, and the decode of a master clear or a wake-up in the running state. The bench provokes this by raising `por_evt` together with `wake_evt`, and then together with `mclr_evt`. In both cases the recorded stage trace must be the plain power sequence for the sampled mode, with exact durations. A brown-out is also injected while the crystal wait is running, and the trace that follows must be a complete fresh sequence whose counts start from zero.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [2:0] {
        OSC_LP    = 3'd0,
        OSC_XT    = 3'd1,
        OSC_HS    = 3'd2,
        OSC_HSPLL = 3'd3,
        OSC_RC    = 3'd4,
        OSC_RCIO  = 3'd5,
        OSC_EC    = 3'd6,
        OSC_ECIO  = 3'd7
    } osc_mode_e;

    typedef enum logic [2:0] {
        STG_RUN  = 3'd0,
        STG_POD  = 3'd1,
        STG_PWRT = 3'd2,
        STG_OST  = 3'd3,
        STG_EXTW = 3'd4,
        STG_LOCK = 3'd5,
        STG_MCLR = 3'd6
    } stage_e;

    typedef struct packed {
        osc_mode_e mode;
        logic      pwrt_on;
    } boot_cfg_t;

    typedef struct packed {
        logic pod;
        logic pwrt;
        logic ost;
        logic extw;
        logic lock;
    } stage_flags_t;

    function automatic logic needs_xtal_wait(osc_mode_e m);
        return (m inside {OSC_LP, OSC_XT, OSC_HS, OSC_HSPLL});
    endfunction

    function automatic logic uses_ext_clk(osc_mode_e m);
        return (m inside {OSC_EC, OSC_ECIO});
    endfunction

    function automatic logic uses_pll(osc_mode_e m);
        return (m == OSC_HSPLL);
    endfunction

    // first clock-related stage for a configuration, RUN if none applies
    function automatic stage_e osc_stage(boot_cfg_t c);
        if (needs_xtal_wait(c.mode)) return STG_OST;
        if (uses_ext_clk(c.mode))    return STG_EXTW;
        return STG_RUN;
    endfunction

    function automatic stage_e stage_successor(stage_e s, boot_cfg_t c);
        case (s)
            STG_POD:            return c.pwrt_on ? STG_PWRT : osc_stage(c);
            STG_PWRT:           return osc_stage(c);
            STG_OST, STG_EXTW:  return uses_pll(c.mode) ? STG_LOCK : STG_RUN;
            default:            return STG_RUN;
        endcase
    endfunction

    function automatic stage_flags_t decode_flags(stage_e s);
        stage_flags_t f;
        f      = '0;
        f.pod  = (s == STG_POD);
        f.pwrt = (s == STG_PWRT);
        f.ost  = (s == STG_OST);
        f.extw = (s == STG_EXTW);
        f.lock = (s == STG_LOCK);
        return f;
    endfunction

endpackage

// File: rtl/pwrup_interval_cnt.sv
module pwrup_interval_cnt #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = step && (cnt_q == (limit - 1'b1));

    // the count never passes the limit of the running stage
    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit); // R5

    AST_CNT_STILL: assert property (@(posedge clk) disable iff (rst)
        (!$past(step) && !$past(clear)) |-> $stable(cnt_q)); // R3

endmodule

// File: rtl/pwrup_stage_ctrl.sv
module pwrup_stage_ctrl
    import pwrup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      power_evt,
    input  logic      mclr_evt,
    input  logic      wake_evt,
    input  boot_cfg_t cfg_in,
    input  logic      expire,
    output stage_e    stage_q,
    output logic      restart
);

    stage_e    stage_d;
    boot_cfg_t cfg_q;

    always_comb begin
        stage_d = stage_q;
        if (power_evt) begin
            stage_d = STG_POD;
        end else if (stage_q == STG_RUN) begin
            if (mclr_evt) begin
                stage_d = STG_MCLR;
            end else if (wake_evt) begin
                stage_d = osc_stage(cfg_q);
            end
        end else if (expire) begin
            stage_d = stage_successor(stage_q, cfg_q);
        end
    end

    assign restart = power_evt || (stage_d != stage_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_POD;
            cfg_q   <= cfg_in;
        end else begin
            stage_q <= stage_d;
            if (power_evt) begin
                cfg_q <= cfg_in;
            end
        end
    end

    AST_POWER_TO_POD: assert property (@(posedge clk) disable iff (rst)
        power_evt |=> (stage_q == STG_POD)); // R2

    AST_PWRT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_PWRT) |-> cfg_q.pwrt_on); // R4

    AST_XTAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_OST) |-> needs_xtal_wait(cfg_q.mode)); // R5

    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_EXTW) |-> uses_ext_clk(cfg_q.mode)); // R6

    AST_LOCK_AFTER_OST: assert property (@(posedge clk) disable iff (rst)
        ((stage_q == STG_LOCK) && ($past(stage_q) != STG_LOCK))
            |-> ($past(stage_q) == STG_OST)); // R7

    AST_PLL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((stage_q == STG_RUN) && ($past(stage_q) != STG_RUN) &&
         ($past(stage_q) != STG_MCLR) && (cfg_q.mode == OSC_HSPLL))
            |-> ($past(stage_q) == STG_LOCK)); // R8

    AST_BUSY_NO_MCLR: assert property (@(posedge clk) disable iff (rst)
        ((stage_q != STG_RUN) && !power_evt) |=> (stage_q != STG_MCLR)); // R11

    AST_MCLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ((stage_q == STG_MCLR) && !power_evt) |=> (stage_q == STG_RUN)); // R10

endmodule

// File: rtl/pwrup_hold_seq.sv
module pwrup_hold_seq
    import pwrup_pkg::*;
#(
    parameter int POD_TICKS  = 4,
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int EXT_CYCLES = 3,
    parameter int LOCK_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_evt,
    input  logic       bor_evt,
    input  logic       mclr_evt,
    input  logic       wake_evt,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en,
    input  logic       slow_tick,
    output logic       hold_rst,
    output logic       pod_busy,
    output logic       pwrt_busy,
    output logic       ost_busy,
    output logic       extclk_busy,
    output logic       lock_busy
);

    localparam int MAX_AB  = (POD_TICKS > PWRT_TICKS) ? POD_TICKS : PWRT_TICKS;
    localparam int MAX_CD  = (OST_CYCLES > EXT_CYCLES) ? OST_CYCLES : EXT_CYCLES;
    localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAX_ALL = (MAX_ABC > LOCK_TICKS) ? MAX_ABC : LOCK_TICKS;
    localparam int CW      = $clog2(MAX_ALL + 1);

    stage_e        stage_q;
    logic          restart;
    logic          expire;
    logic          step;
    logic [CW-1:0] limit;
    boot_cfg_t     cfg_in;
    stage_flags_t  flags;
    logic          power_evt;

    assign power_evt      = por_evt || bor_evt;
    assign cfg_in.mode    = osc_mode_e'(osc_mode);
    assign cfg_in.pwrt_on = pwrt_en;

    // per-stage length and count source
    always_comb begin
        case (stage_q)
            STG_POD:  begin limit = CW'(POD_TICKS);  step = slow_tick; end
            STG_PWRT: begin limit = CW'(PWRT_TICKS); step = slow_tick; end
            STG_OST:  begin limit = CW'(OST_CYCLES); step = 1'b1;      end
            STG_EXTW: begin limit = CW'(EXT_CYCLES); step = 1'b1;      end
            STG_LOCK: begin limit = CW'(LOCK_TICKS); step = slow_tick; end
            STG_MCLR: begin limit = CW'(1);          step = 1'b1;      end
            default:  begin limit = CW'(1);          step = 1'b0;      end
        endcase
    end

    pwrup_stage_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .power_evt (power_evt),
        .mclr_evt  (mclr_evt),
        .wake_evt  (wake_evt),
        .cfg_in    (cfg_in),
        .expire    (expire),
        .stage_q   (stage_q),
        .restart   (restart)
    );

    pwrup_interval_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (restart),
        .step   (step),
        .limit  (limit),
        .expire (expire)
    );

    assign flags       = decode_flags(stage_q);
    assign hold_rst    = (stage_q != STG_RUN);
    assign pod_busy    = flags.pod;
    assign pwrt_busy   = flags.pwrt;
    assign ost_busy    = flags.ost;
    assign extclk_busy = flags.extw;
    assign lock_busy   = flags.lock;

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pod_busy, pwrt_busy, ost_busy, extclk_busy, lock_busy})); // R8

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pod_busy || pwrt_busy || ost_busy || extclk_busy || lock_busy) |-> hold_rst); // R8

    AST_WAKE_RC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!hold_rst && !power_evt && !mclr_evt && !wake_evt) |=> !hold_rst); // R9

endmodule

// File: tb/pwrup_hold_seq_test.sv
`timescale 1ns/1ps
module pwrup_hold_seq_test;

    localparam int P_POD  = 2;
    localparam int P_PWRT = 5;
    localparam int P_OST  = 7;
    localparam int P_EXT  = 3;
    localparam int P_LOCK = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_evt = 1'b0, bor_evt = 1'b0, mclr_evt = 1'b0, wake_evt = 1'b0;
    logic [2:0] osc_mode = 3'd3;
    logic       pwrt_en = 1'b1;
    logic       slow_tick = 1'b0;
    logic       hold_rst, pod_busy, pwrt_busy, ost_busy, extclk_busy, lock_busy;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pwrup_hold_seq #(
        .POD_TICKS(P_POD), .PWRT_TICKS(P_PWRT), .OST_CYCLES(P_OST),
        .EXT_CYCLES(P_EXT), .LOCK_TICKS(P_LOCK)
    ) uut (
        .clk(clk), .rst(rst), .por_evt(por_evt), .bor_evt(bor_evt),
        .mclr_evt(mclr_evt), .wake_evt(wake_evt), .osc_mode(osc_mode),
        .pwrt_en(pwrt_en), .slow_tick(slow_tick), .hold_rst(hold_rst),
        .pod_busy(pod_busy), .pwrt_busy(pwrt_busy), .ost_busy(ost_busy),
        .extclk_busy(extclk_busy), .lock_busy(lock_busy)
    );

    // slow timebase: one pulse every third cycle
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 3;
        slow_tick = (tdiv == 0);
    end

    // stage trace recorder
    int tr_id [16];
    int tr_cyc[16];
    int tr_tck[16];
    int tr_n    = 0;
    int last_id = 0;
    bit clr_req = 1'b0;

    function automatic int cur_id();
        if (!hold_rst)   return 0;
        if (pod_busy)    return 1;
        if (pwrt_busy)   return 2;
        if (ost_busy)    return 3;
        if (extclk_busy) return 4;
        if (lock_busy)   return 5;
        return 6;
    endfunction

    always @(negedge clk) begin
        int id;
        id = cur_id();
        if (clr_req) begin
            clr_req = 1'b0;
            tr_n    = 0;
            last_id = id;
        end else begin
            if (id != 0 && id != last_id && tr_n < 16) begin
                tr_id[tr_n]  = id;
                tr_cyc[tr_n] = 0;
                tr_tck[tr_n] = 0;
                tr_n++;
            end
            if (id != 0 && tr_n > 0) begin
                tr_cyc[tr_n-1]++;
                if (slow_tick) tr_tck[tr_n-1]++;
            end
            last_id = id;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected trace
    int exp_id[8];
    int exp_n;

    task automatic build_exp(input int m, input bit pw, input int kind);
        exp_n = 0;
        if (kind == 2) begin
            exp_id[exp_n++] = 6;
            return;
        end
        if (kind == 0) begin
            exp_id[exp_n++] = 1;
            if (pw) exp_id[exp_n++] = 2;
        end
        if (m <= 3)      exp_id[exp_n++] = 3;
        else if (m >= 6) exp_id[exp_n++] = 4;
        if (m == 3)      exp_id[exp_n++] = 5;
    endtask

    function automatic string id_req(input int id);
        case (id)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check_trace(input string req);
        check(req, "stage count", tr_n, exp_n);
        for (int i = 0; i < exp_n && i < tr_n; i++) begin
            check(req, $sformatf("stage %0d id", i), tr_id[i], exp_id[i]);
            if (tr_id[i] == exp_id[i]) begin
                case (tr_id[i])
                    1: check(id_req(1), "pod ticks",  tr_tck[i], P_POD);
                    2: check(id_req(2), "pwrt ticks", tr_tck[i], P_PWRT);
                    3: check(id_req(3), "ost cycles", tr_cyc[i], P_OST);
                    4: check(id_req(4), "ext cycles", tr_cyc[i], P_EXT);
                    5: check(id_req(5), "lock ticks", tr_tck[i], P_LOCK);
                    default: check(id_req(6), "mclr cycles", tr_cyc[i], 1);
                endcase
            end
        end
        check("R8", "hold released", int'(hold_rst), 0);
    endtask

    // which: 0 por, 1 bor, 2 mclr, 3 wake, 4 por+wake, 5 por+mclr
    task automatic pulse(input int which, input bit clr);
        @(posedge clk); #1;
        por_evt  = (which == 0 || which == 4 || which == 5);
        bor_evt  = (which == 1);
        mclr_evt = (which == 2 || which == 5);
        wake_evt = (which == 3 || which == 4);
        if (clr) clr_req = 1'b1;
        @(posedge clk); #1;
        por_evt = 1'b0; bor_evt = 1'b0; mclr_evt = 1'b0; wake_evt = 1'b0;
    endtask

    task automatic wait_release();
        int n;
        n = 0;
        @(negedge clk);
        @(negedge clk);
        while (hold_rst && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_cfg(input int m, input bit pw);
        @(posedge clk); #1;
        osc_mode = 3'(m);
        pwrt_en  = pw;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "hold in reset", int'(hold_rst), 1);
        check("R1", "pod flag in reset", int'(pod_busy), 1);
        check("R1", "other flags in reset",
              int'({pwrt_busy, ost_busy, extclk_busy, lock_busy}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pod after reset", int'(pod_busy), 1);
        wait_release();
        check("R1", "release after reset", int'(hold_rst), 0);

        // sweep over every mode and timer enable
        for (int m = 0; m < 8; m++) begin
            for (int pw = 0; pw < 2; pw++) begin
                set_cfg(m, pw[0]);
                pulse((m % 2) ? 1 : 0, 1'b1);
                wait_release();
                build_exp(m, pw[0], 0);
                check_trace("R8");
                pulse(3, 1'b1);
                wait_release();
                build_exp(m, pw[0], 1);
                check_trace("R9");
                pulse(2, 1'b1);
                wait_release();
                build_exp(m, pw[0], 2);
                check_trace("R10");
            end
        end

        // R12: configuration latched at power event
        set_cfg(4, 1'b0);
        pulse(0, 1'b1);
        wait_release();
        set_cfg(2, 1'b1);
        pulse(3, 1'b1);
        wait_release();
        build_exp(4, 1'b0, 1);
        check_trace("R12");
        pulse(0, 1'b1);
        wait_release();
        build_exp(2, 1'b1, 0);
        check_trace("R12");

        // R11: mclr and wake ignored while busy
        set_cfg(1, 1'b1);
        pulse(0, 1'b1);
        while (!pwrt_busy) @(negedge clk);
        pulse(2, 1'b0);
        pulse(3, 1'b0);
        wait_release();
        build_exp(1, 1'b1, 0);
        check_trace("R11");

        // R2: power event together with wake, and with mclr
        set_cfg(0, 1'b0);
        pulse(4, 1'b1);
        wait_release();
        build_exp(0, 1'b0, 0);
        check_trace("R2");
        pulse(5, 1'b1);
        wait_release();
        build_exp(0, 1'b0, 0);
        check_trace("R2");

        // R2: brown-out during the crystal wait restarts everything
        set_cfg(3, 1'b1);
        pulse(0, 1'b1);
        while (!ost_busy) @(negedge clk);
        pulse(1, 1'b1);
        wait_release();
        build_exp(3, 1'b1, 0);
        check_trace("R2");

        // R10: mclr wins over wake in the same cycle
        @(posedge clk); #1;
        mclr_evt = 1'b1; wake_evt = 1'b1; clr_req = 1'b1;
        @(posedge clk); #1;
        mclr_evt = 1'b0; wake_evt = 1'b0;
        wait_release();
        build_exp(3, 1'b1, 2);
        check_trace("R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule